// File: doc/BRIEF.md
# DMA Interrupt and Channel-Enable Register Block

This block holds the interrupt and channel-enable state of an eight-channel DMA controller. Each channel can raise five kinds of event: transfer chain done, block done, source transaction, destination transaction and bus error. Every event is caught in a per-channel latch. Software chooses through mask registers which latched events reach the single interrupt line. It reads the masked view per event type, or a five-bit summary with one bit per type. It acknowledges events by writing ones to clear registers.

The mask and channel-enable registers use a write-enable scheme. In a 16-bit write, bits 15:8 choose which channels change, and bits 7:0 give their new values. Software can therefore set or clear one channel without a read-modify-write. A channel's enable bit drops by itself when that channel's transfer chain completes. Enable bits can only be set while a global enable bit is on. The data path and the arbitration sit elsewhere. This block only keeps and reports the state.

Register reads are combinational from the address. Writes take effect at the next rising clock edge. Reset is an active-low input that is asserted at once and released through a two-stage synchronizer.

Top module: `dmairq_regs`

## Requirements
- R1: After reset, every latch, mask, enable bit, the global enable, the summary and the interrupt line read 0.
- R2: An event pulse on type k (0 transfer done, 1 block done, 2 source transaction, 3 destination transaction, 4 bus error) for channel n sets raw bit n of type k at the next edge, whatever the mask. Raw type k reads at byte address 0x2C0 + 8k.
- R3: The status of type k, read at 0x2E8 + 8k, equals raw AND mask for that type.
- R4: A write to the clear register of type k (0x338 + 8k) clears each raw bit whose data bit 7:0 is 1. A 0 data bit leaves the raw bit unchanged. If an event on the same bit arrives in the same cycle, the bit stays set.
- R5: A write to the mask of type k (0x310 + 8k) changes mask bit n to data bit n only when data bit n+8 is 1. All other mask bits keep their value.
- R6: A write to the channel-enable register (0x3A0) follows the same scheme: data bit n+8 selects channel n, and data bit n gives the new value.
- R7: A transfer-done event on channel n clears enable bit n at the next edge. This takes priority over a write that sets that bit in the same cycle.
- R8: Summary bit k (at 0x360) is the OR of all status bits of type k. The interrupt line is the OR of the summary bits.
- R9: The global enable is data bit 0 at 0x398. While it is 0, no enable bit can become 1, but enable bits can still be cleared. Turning the global enable off leaves the enable bits as they are.
- R10: Writes to the raw, status and summary addresses change nothing. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_addr | input | 10 | Byte address of the register |
| reg_wdata | input | 16 | Write data; 15:8 are channel write enables where used |
| reg_rdata | output | 8 | Read data of the addressed register |
| ev_xfer | input | 8 | Per-channel transfer-chain-done pulses |
| ev_block | input | 8 | Per-channel block-done pulses |
| ev_srctx | input | 8 | Per-channel source transaction pulses |
| ev_dsttx | input | 8 | Per-channel destination transaction pulses |
| ev_buserr | input | 8 | Per-channel bus error pulses |
| chan_en | output | 8 | Channel enable bits |
| irq | output | 1 | Combined interrupt |

## Verification
A corrupt latch or mask bit reaches the ports in the same cycle: the interrupt line changes at once, and a read of the type's status, summary or mask address shows the bad bit. A lost or stuck enable bit appears directly on chan_en one edge after the faulty update. For these reasons the bench checks the interrupt line and the enable bits against its own model on every clock, and reads back the registers after each directed step. A clear that wrongly beats a simultaneous event, or a write that ignores its enable byte, leaves a wrong bit that the next read back exposes.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int NTYPE       = 5;
  localparam int STRIDE      = 8;
  localparam int RAW_BASE    = 'h2C0;
  localparam int STAT_BASE   = 'h2E8;
  localparam int MASK_BASE   = 'h310;
  localparam int CLR_BASE    = 'h338;
  localparam int SUMM_ADDR   = 'h360;
  localparam int GEN_ADDR    = 'h398;
  localparam int CHEN_ADDR   = 'h3A0;
  localparam int WE_LSB      = 8;
  localparam int TYPE_XFER   = 0;
endpackage

// File: rtl/dmairq_rst_sync.sv
module dmairq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/dmairq_type_bank.sv
module dmairq_type_bank #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ev,
  input  logic           clr_hit,
  input  logic           mask_hit,
  input  logic [NCH-1:0] wval,
  input  logic [NCH-1:0] we,
  output logic [NCH-1:0] raw,
  output logic [NCH-1:0] mask,
  output logic [NCH-1:0] status
);
  logic [NCH-1:0] raw_q, raw_d, mask_q, mask_d;
  logic           raw_ce, mask_ce;

  always_comb begin
    raw_ce  = clr_hit | (|ev);
    raw_d   = (raw_q & ~(clr_hit ? wval : '0)) | ev;
    mask_ce = mask_hit;
    mask_d  = (mask_q & ~we) | (wval & we);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      if (raw_ce)  raw_q  <= raw_d;
      if (mask_ce) mask_q <= mask_d;
    end
  end

  assign raw    = raw_q;
  assign mask   = mask_q;
  assign status = raw_q & mask_q;

  assert_event_sets_raw_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((raw_q & $past(ev)) == $past(ev)));

  assert_clear_drops_raw_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && |(wval & ~ev)) |=> ((raw_q & $past(wval & ~ev)) == '0));

  assert_mask_keeps_unselected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mask_hit |=> ((mask_q & ~$past(we)) == ($past(mask_q) & ~$past(we))));
endmodule

// File: rtl/dmairq_chen.sv
module dmairq_chen #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_hit,
  input  logic [NCH-1:0] wval,
  input  logic [NCH-1:0] we,
  input  logic           glob_en,
  input  logic [NCH-1:0] done,
  output logic [NCH-1:0] chen
);
  logic [NCH-1:0] chen_q, chen_d, set_req, clr_req;
  logic           chen_ce;

  always_comb begin
    set_req = (wr_hit && glob_en) ? (we & wval) : '0;
    clr_req = wr_hit ? (we & ~wval) : '0;
    chen_ce = wr_hit | (|done);
    chen_d  = ((chen_q & ~clr_req) | set_req) & ~done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       chen_q <= '0;
    else if (chen_ce) chen_q <= chen_d;
  end

  assign chen = chen_q;

  assert_done_clears_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|done) |=> ((chen_q & $past(done)) == '0));

  assert_no_set_while_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_en) |=> ((chen_q & ~$past(chen_q)) == '0));
endmodule

// File: rtl/dmairq_regs.sv
module dmairq_regs #(
  parameter int NCH = 8,
  parameter int AW  = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [15:0]    reg_wdata,
  output logic [7:0]     reg_rdata,
  input  logic [NCH-1:0] ev_xfer,
  input  logic [NCH-1:0] ev_block,
  input  logic [NCH-1:0] ev_srctx,
  input  logic [NCH-1:0] ev_dsttx,
  input  logic [NCH-1:0] ev_buserr,
  output logic [NCH-1:0] chan_en,
  output logic           irq
);
  import dmairq_pkg::*;

  function automatic logic [AW-1:0] at(input int base, input int k);
    return AW'(base + STRIDE * k);
  endfunction

  logic rst_int_n;
  logic [NTYPE-1:0][NCH-1:0] ev_all, raw_all, mask_all, stat_all;
  logic [NTYPE-1:0]          summ;
  logic [NCH-1:0]            wval, we;
  logic                      gen_q, gen_d, gen_ce, chen_hit;

  dmairq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n));

  assign ev_all = {ev_buserr, ev_dsttx, ev_srctx, ev_block, ev_xfer};
  assign wval   = reg_wdata[NCH-1:0];
  assign we     = reg_wdata[WE_LSB +: NCH];

  for (genvar k = 0; k < NTYPE; k++) begin : g_type
    logic clr_hit, mask_hit;
    assign clr_hit  = reg_wr && (reg_addr == at(CLR_BASE, k));
    assign mask_hit = reg_wr && (reg_addr == at(MASK_BASE, k));

    dmairq_type_bank #(.NCH(NCH)) u_bank (
      .clk(clk), .rst_n(rst_int_n), .ev(ev_all[k]),
      .clr_hit(clr_hit), .mask_hit(mask_hit), .wval(wval), .we(we),
      .raw(raw_all[k]), .mask(mask_all[k]), .status(stat_all[k])
    );

    assign summ[k] = |stat_all[k];
  end

  always_comb begin
    gen_ce = reg_wr && (reg_addr == AW'(GEN_ADDR));
    gen_d  = reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  gen_q <= 1'b0;
    else if (gen_ce) gen_q <= gen_d;
  end

  assign chen_hit = reg_wr && (reg_addr == AW'(CHEN_ADDR));

  dmairq_chen #(.NCH(NCH)) u_chen (
    .clk(clk), .rst_n(rst_int_n), .wr_hit(chen_hit), .wval(wval), .we(we),
    .glob_en(gen_q), .done(ev_all[TYPE_XFER]), .chen(chan_en)
  );

  assign irq = |summ;

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NTYPE; k++) begin
      if (reg_addr == at(RAW_BASE, k))  reg_rdata = 8'(raw_all[k]);
      if (reg_addr == at(STAT_BASE, k)) reg_rdata = 8'(stat_all[k]);
      if (reg_addr == at(MASK_BASE, k)) reg_rdata = 8'(mask_all[k]);
    end
    if (reg_addr == AW'(SUMM_ADDR)) reg_rdata = 8'(summ);
    if (reg_addr == AW'(GEN_ADDR))  reg_rdata = 8'(gen_q);
    if (reg_addr == AW'(CHEN_ADDR)) reg_rdata = 8'(chan_en);
  end
endmodule

// File: tb/dmairq_regs_tb.sv
module dmairq_regs_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [9:0] reg_addr;
  logic [15:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [7:0] ev_xfer, ev_block, ev_srctx, ev_dsttx, ev_buserr;
  logic [7:0] chan_en;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit live  = 0;
  bit ended = 0;

  logic [7:0] m_raw [5];
  logic [7:0] m_mask [5];
  logic [7:0] m_chen;
  logic       m_gen;

  always #10 clk = ~clk;

  dmairq_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_xfer(ev_xfer), .ev_block(ev_block), .ev_srctx(ev_srctx),
    .ev_dsttx(ev_dsttx), .ev_buserr(ev_buserr),
    .chan_en(chan_en), .irq(irq)
  );

  function automatic logic [7:0] ev_of(input int k);
    case (k)
      0: return ev_xfer;
      1: return ev_block;
      2: return ev_srctx;
      3: return ev_dsttx;
      default: return ev_buserr;
    endcase
  endfunction

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 5; k++) begin m_raw[k] = 0; m_mask[k] = 0; end
      m_chen = 0;
      m_gen  = 0;
    end else begin
      logic [7:0] en;
      logic [7:0] vv;
      logic       g_old;
      en = reg_wdata[15:8];
      vv = reg_wdata[7:0];
      g_old = m_gen;
      for (int k = 0; k < 5; k++) begin
        if (reg_wr && reg_addr == 10'(32'h338 + 8 * k)) m_raw[k] = m_raw[k] & ~vv;
        m_raw[k] = m_raw[k] | ev_of(k);
        if (reg_wr && reg_addr == 10'(32'h310 + 8 * k))
          for (int n = 0; n < 8; n++) if (en[n]) m_mask[k][n] = vv[n];
      end
      if (reg_wr && reg_addr == 10'h398) m_gen = vv[0];
      if (reg_wr && reg_addr == 10'h3A0)
        for (int n = 0; n < 8; n++)
          if (en[n] && (!vv[n] || g_old)) m_chen[n] = vv[n];
      m_chen = m_chen & ~ev_xfer;
    end
  end

  function automatic logic [7:0] m_read(input logic [9:0] a);
    logic [7:0] s;
    s = 0;
    for (int k = 0; k < 5; k++) begin
      if (a == 10'(32'h2C0 + 8 * k)) return m_raw[k];
      if (a == 10'(32'h2E8 + 8 * k)) return m_raw[k] & m_mask[k];
      if (a == 10'(32'h310 + 8 * k)) return m_mask[k];
      if ((m_raw[k] & m_mask[k]) != 0) s[k] = 1'b1;
    end
    if (a == 10'h360) return s;
    if (a == 10'h398) return {7'b0, m_gen};
    if (a == 10'h3A0) return m_chen;
    return 8'h00;
  endfunction

  function automatic logic m_irq();
    logic r;
    r = 0;
    for (int k = 0; k < 5; k++) r = r | (|(m_raw[k] & m_mask[k]));
    return r;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // every-clock comparison of the outputs that do not depend on the address
  always @(negedge clk) begin
    if (live && !ended) begin
      chk("R8 irq", {7'b0, irq}, {7'b0, m_irq()});
      chk("R7 chan_en", chan_en, m_chen);
    end
  end

  task automatic drv(input bit wr, input logic [9:0] a, input logic [15:0] d,
                     input logic [7:0] e0, input logic [7:0] e1, input logic [7:0] e2,
                     input logic [7:0] e3, input logic [7:0] e4);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    ev_xfer = e0; ev_block = e1; ev_srctx = e2; ev_dsttx = e3; ev_buserr = e4;
  endtask

  task automatic wr(input logic [9:0] a, input logic [15:0] d);
    drv(1'b1, a, d, 0, 0, 0, 0, 0);
  endtask

  // read with a fixed expected value, also cross-checked with the model
  task automatic rdx(input logic [9:0] a, input logic [7:0] exp, input string req);
    drv(1'b0, a, 16'h0, 0, 0, 0, 0, 0);
    #1;
    chk(req, reg_rdata, exp);
    chk({req, " model"}, reg_rdata, m_read(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [9:0] alist [14];
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    ev_xfer = 0; ev_block = 0; ev_srctx = 0; ev_dsttx = 0; ev_buserr = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);
    live = 1;

    // R1 reset state
    for (int k = 0; k < 5; k++) begin
      rdx(10'(32'h2C0 + 8 * k), 8'h00, "R1 raw");
      rdx(10'(32'h310 + 8 * k), 8'h00, "R1 mask");
    end
    rdx(10'h360, 8'h00, "R1 summary");
    rdx(10'h398, 8'h00, "R1 global");
    rdx(10'h3A0, 8'h00, "R1 enable");
    chk("R1 irq", {7'b0, irq}, 8'h00);

    // R2 raw latch with masks off
    drv(1'b0, 10'h0, 16'h0, 0, 8'h08, 0, 0, 8'h01);
    rdx(10'h2C8, 8'h08, "R2 raw block");
    rdx(10'h2E0, 8'h01, "R2 raw buserr");
    rdx(10'h2F0, 8'h00, "R3 status masked off");
    rdx(10'h360, 8'h00, "R8 summary masked off");
    chk("R8 irq low", {7'b0, irq}, 8'h00);

    // R5 / R3 / R8 mask writes
    wr(10'h318, 16'h0808);
    rdx(10'h318, 8'h08, "R5 mask set ch3");
    rdx(10'h2F0, 8'h08, "R3 status block");
    rdx(10'h360, 8'h02, "R8 summary block");
    chk("R8 irq high", {7'b0, irq}, 8'h01);
    wr(10'h318, 16'h00F7);
    rdx(10'h318, 8'h08, "R5 no enables");
    wr(10'h318, 16'h0300);
    rdx(10'h318, 8'h08, "R5 other channels");

    // R4 clears
    wr(10'h340, 16'h00F7);
    rdx(10'h2C8, 8'h08, "R4 zero bit keeps");
    wr(10'h340, 16'h0008);
    rdx(10'h2C8, 8'h00, "R4 one bit clears");
    chk("R8 irq after clear", {7'b0, irq}, 8'h00);
    drv(1'b1, 10'h358, 16'h0001, 0, 0, 0, 0, 8'h01);
    rdx(10'h2E0, 8'h01, "R4 event beats clear");
    wr(10'h358, 16'h0001);
    rdx(10'h2E0, 8'h00, "R4 clear after");

    // R10 read-only and unmapped
    wr(10'h2E0, 16'hFFFF);
    rdx(10'h2E0, 8'h00, "R10 raw read-only");
    wr(10'h308, 16'hFFFF);
    rdx(10'h330, 8'h00, "R10 status write no mask");
    wr(10'h360, 16'hFFFF);
    rdx(10'h360, 8'h00, "R10 summary read-only");
    rdx(10'h001, 8'h00, "R10 unmapped");
    rdx(10'h3A8, 8'h00, "R10 unmapped high");

    // R9 / R6 / R7 channel enables
    wr(10'h3A0, 16'h0101);
    rdx(10'h3A0, 8'h00, "R9 set blocked");
    wr(10'h398, 16'h0001);
    rdx(10'h398, 8'h01, "R9 global on");
    wr(10'h3A0, 16'h0505);
    rdx(10'h3A0, 8'h05, "R6 set two");
    wr(10'h3A0, 16'h0400);
    rdx(10'h3A0, 8'h01, "R6 clear one");
    wr(10'h3A0, 16'h00FF);
    rdx(10'h3A0, 8'h01, "R6 no enables");
    drv(1'b0, 10'h0, 16'h0, 8'h01, 0, 0, 0, 0);
    rdx(10'h3A0, 8'h00, "R7 self clear");
    rdx(10'h2C0, 8'h01, "R2 raw xfer");
    drv(1'b1, 10'h3A0, 16'h0202, 8'h02, 0, 0, 0, 0);
    rdx(10'h3A0, 8'h00, "R7 done beats set");
    wr(10'h3A0, 16'h0808);
    wr(10'h398, 16'h0000);
    rdx(10'h3A0, 8'h08, "R9 global off keeps");
    wr(10'h3A0, 16'h0800);
    rdx(10'h3A0, 8'h00, "R9 clear while off");

    // mixed traffic against the model
    alist = '{10'h2C0, 10'h2D8, 10'h2F8, 10'h310, 10'h320, 10'h330, 10'h338,
              10'h348, 10'h358, 10'h360, 10'h398, 10'h3A0, 10'h3A0, 10'h398};
    for (int i = 0; i < 3000; i++) begin
      logic [9:0] a;
      a = alist[$urandom_range(0, 13)];
      drv($urandom_range(0, 1) == 1, a, 16'($urandom),
          ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'h00,
          ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'h00,
          ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'h00,
          ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'h00,
          ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'h00);
      if (i % 4 == 3) begin
        drv(1'b0, alist[$urandom_range(0, 13)], 16'h0, 0, 0, 0, 0, 0);
        #1;
        chk("R3 R5 R6 random read", reg_rdata, m_read(reg_addr));
      end
    end

    drv(1'b0, 10'h0, 16'h0, 0, 0, 0, 0, 0);
    @(negedge clk);
    ended = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule